// File: doc/BRIEF.md
# Byte FIFO Pair with Interrupt Status

This block sits between a simple register port and a serial bus sequencer. Software pushes bytes into a transmit FIFO and pops bytes from a receive FIFO through a valid/write/address/data port, while the sequencer drains the transmit side and fills the receive side through its own handshake-free strobes. Each FIFO can be flushed by a control bit that stays set while the flush runs and clears by itself when the flush is finished. FIFO traffic from either side is blocked while a flush is running.

Interrupt status is held as a 32-bit raw vector. Some bits follow FIFO occupancy directly (empty, full, and threshold flags). Others latch events until software clears them: a transmit overrun, transaction completion with or without a stop condition, lost arbitration, bus error, and four slave-side events. A mask register selects which raw bits reach a masked view, and a single interrupt line is the OR of that masked view. The two thresholds are programmable and clamp to half the FIFO depth minus one.

Top module: `xfer_fifo_irq`

## Requirements
- R1: Writing a 1 to control bit 7 (transmit) or bit 8 (receive) at offset 0x00 starts a flush; that bit reads 1 for FLUSH_CYCLES cycles, after which it reads 0 and the FIFO is empty.
- R2: While a FIFO is being flushed, register writes to the transmit data offset 0x04, reads of the receive data offset 0x08 (which return 0), sequencer pops and sequencer pushes on that FIFO have no effect, and seq_tx_avail is 0 during a transmit flush.
- R3: Both FIFOs are first-in first-out: the sequencer sees transmit bytes on seq_tx_data in write order, and reads of offset 0x08 return received bytes in push order.
- R4: A read of offset 0x08 while the receive FIFO is empty returns 0 and leaves the FIFO state unchanged.
- R5: Raw bits follow occupancy every cycle: bit 0 TX empty, bit 1 TX occupancy at or below the TX threshold, bit 2 TX full, bit 4 RX empty, bit 5 RX occupancy at or above the RX threshold, bit 6 RX full.
- R6: A write to offset 0x04 while the transmit FIFO is full discards the byte and sets sticky raw bit 3.
- R7: A one-cycle pulse on evt_done, evt_done_nostop, evt_arb_lost and evt_bus_err sets sticky raw bits 19, 28, 24 and 25; evt_slave[0..3] sets sticky bits 16, 17, 18 and 20.
- R8: Writing ones to the clear offset 0x20 clears those sticky bits that lie in 0x131F007F; occupancy bits are unaffected, an event arriving in the same cycle as its clear leaves the bit set, and raw bits outside 0x131F007F are always 0.
- R9: The mask at offset 0x14 keeps only bits 28..0 (bits 31..29 read 0); the masked view at offset 0x1C equals raw (offset 0x18) AND mask, and irq is 1 exactly when the masked view is nonzero.
- R10: A threshold written at offset 0x0C (TX) or 0x10 (RX) above DEPTH/2-1 is stored as DEPTH/2-1.
- R11: After reset both FIFOs are empty, the mask, both thresholds and all sticky bits are 0, so raw reads 0x33 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |
| seq_tx_pop | input | 1 | Sequencer takes the head transmit byte |
| seq_tx_data | output | 8 | Head of the transmit FIFO |
| seq_tx_avail | output | 1 | Transmit byte available to the sequencer |
| seq_rx_push | input | 1 | Sequencer delivers a received byte |
| seq_rx_data | input | 8 | Received byte |
| evt_done | input | 1 | Transaction finished with stop |
| evt_done_nostop | input | 1 | Transaction finished without stop |
| evt_arb_lost | input | 1 | Arbitration lost |
| evt_bus_err | input | 1 | Bus error |
| evt_slave | input | 4 | Slave-side event pulses |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions watch, on every cycle, that FIFO counts stay in range, that a pop from an empty receive FIFO leaves it empty, that a started flush is running on the next cycle, that receive occupancy is frozen until the flush completes, that a sticky bit only drops when it was cleared, that reserved raw and mask bits stay zero, that thresholds never exceed their limit, and that a write into a full transmit FIFO raises the overrun bit. Data ordering, the exact flush length, dropped bytes during a flush, the return value of an empty read, the set-over-clear priority and the exact raw and masked values after a sequence of events can only be shown by the bench's directed scenarios.

// File: rtl/xfi_pkg.sv
`timescale 1ns/1ps
package xfi_pkg;

    // interrupt bit positions (decoded by software)
    localparam int B_TX_EMPTY   = 0;
    localparam int B_TX_LOW     = 1;
    localparam int B_TX_FULL    = 2;
    localparam int B_TX_OVR     = 3;
    localparam int B_RX_EMPTY   = 4;
    localparam int B_RX_HIGH    = 5;
    localparam int B_RX_FULL    = 6;
    localparam int B_SLV0       = 16;
    localparam int B_SLV1       = 17;
    localparam int B_SLV2       = 18;
    localparam int B_DONE       = 19;
    localparam int B_SLV3       = 20;
    localparam int B_ARB        = 24;
    localparam int B_BERR       = 25;
    localparam int B_DONE_NS    = 28;

    localparam logic [31:0] CLEARABLE  = 32'h131F_007F;
    localparam logic [31:0] MASK_BITS  = 32'h1FFF_FFFF;
    localparam logic [31:0] LEVEL_BITS = 32'h0000_0077;
    localparam logic [31:0] STICKY_BITS = CLEARABLE & ~LEVEL_BITS;

    // control bit positions
    localparam int C_TX_FLUSH = 7;
    localparam int C_RX_FLUSH = 8;

    // register offsets
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_TXDATA = 8'h04;
    localparam logic [7:0] OFS_RXDATA = 8'h08;
    localparam logic [7:0] OFS_TXTHR  = 8'h0C;
    localparam logic [7:0] OFS_RXTHR  = 8'h10;
    localparam logic [7:0] OFS_MASK   = 8'h14;
    localparam logic [7:0] OFS_RAW    = 8'h18;
    localparam logic [7:0] OFS_MSKD   = 8'h1C;
    localparam logic [7:0] OFS_CLEAR  = 8'h20;

endpackage

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    input  logic                         clear,
    output logic [WIDTH-1:0]             head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t   s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic       do_push, do_pop;

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign count = s_q.cnt;
    assign head  = mem_q[s_q.rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push && !full && !clear;
        do_pop  = pop && !empty && !clear;
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wp = bump(s_q.wp);
            if (do_pop)  s_d.rp = bump(s_q.rp);
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= push_data;
    end

    AST_FIFO_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R3
    AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty); // R4

endmodule

// File: rtl/flush_ctl.sv
`timescale 1ns/1ps
module flush_ctl #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNW = $clog2(CYCLES+1);

    typedef struct packed {
        logic           busy;
        logic [CNW-1:0] cnt;
    } fl_st_t;

    fl_st_t s_d, s_q;

    assign busy = s_q.busy;
    assign done = s_q.busy && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (done) begin
            s_d.busy = 1'b0;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNW'(CYCLES-1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_FLUSH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R1

endmodule

// File: rtl/irq_status.sv
`timescale 1ns/1ps
module irq_status
    import xfi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] level,
    input  logic [31:0] set_ev,
    input  logic        clr_we,
    input  logic        mask_we,
    input  logic [31:0] wdata,
    output logic [31:0] raw,
    output logic [31:0] mask,
    output logic [31:0] masked,
    output logic        irq
);
    typedef struct packed {
        logic [31:0] sticky;
        logic [31:0] mask;
    } irq_st_t;

    irq_st_t     s_d, s_q;
    logic [31:0] clr_vec;

    always_comb begin
        clr_vec = clr_we ? (wdata & STICKY_BITS) : '0;
        s_d = s_q;
        s_d.sticky = (s_q.sticky & ~clr_vec) | (set_ev & STICKY_BITS);
        if (mask_we) s_d.mask = wdata & MASK_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raw    = s_q.sticky | (level & LEVEL_BITS);
    assign mask   = s_q.mask;
    assign masked = raw & s_q.mask;
    assign irq    = |masked;

    AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mask[31:29] == 3'b000); // R9
    AST_IRQ_UNMASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R9
    AST_RAW_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~CLEARABLE) == '0); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(s_q.sticky) & ~$past(clr_vec)) & ~s_q.sticky) == '0)); // R8

endmodule

// File: rtl/xfer_fifo_irq.sv
`timescale 1ns/1ps
module xfer_fifo_irq
    import xfi_pkg::*;
#(
    parameter int DEPTH        = 32,
    parameter int FLUSH_CYCLES = 8,
    parameter int ADDR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              seq_tx_pop,
    output logic [7:0]        seq_tx_data,
    output logic              seq_tx_avail,
    input  logic              seq_rx_push,
    input  logic [7:0]        seq_rx_data,
    input  logic              evt_done,
    input  logic              evt_done_nostop,
    input  logic              evt_arb_lost,
    input  logic              evt_bus_err,
    input  logic [3:0]        evt_slave,
    output logic              irq
);
    localparam int CW      = $clog2(DEPTH+1);
    localparam int THW     = $clog2(DEPTH);
    localparam int THR_MAX = DEPTH/2 - 1;

    typedef struct packed {
        logic [THW-1:0] tx_thr;
        logic [THW-1:0] rx_thr;
    } top_st_t;

    top_st_t s_d, s_q;

    logic wr, rd;
    logic hit_ctrl, hit_txd, hit_rxd, hit_txth, hit_rxth, hit_mask, hit_raw, hit_mskd, hit_clr;
    logic tx_busy, tx_done, rx_busy, rx_done;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [7:0]  tx_head, rx_head;
    logic [31:0] lvl, ev, raw, mask, masked;

    assign wr = reg_valid && reg_write;
    assign rd = reg_valid && !reg_write;

    assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign hit_txd  = (reg_addr == ADDR_W'(OFS_TXDATA));
    assign hit_rxd  = (reg_addr == ADDR_W'(OFS_RXDATA));
    assign hit_txth = (reg_addr == ADDR_W'(OFS_TXTHR));
    assign hit_rxth = (reg_addr == ADDR_W'(OFS_RXTHR));
    assign hit_mask = (reg_addr == ADDR_W'(OFS_MASK));
    assign hit_raw  = (reg_addr == ADDR_W'(OFS_RAW));
    assign hit_mskd = (reg_addr == ADDR_W'(OFS_MSKD));
    assign hit_clr  = (reg_addr == ADDR_W'(OFS_CLEAR));

    function automatic logic [THW-1:0] clamp_thr(input logic [31:0] v);
        return (v > 32'(THR_MAX)) ? THW'(THR_MAX) : v[THW-1:0];
    endfunction

    always_comb begin
        s_d = s_q;
        if (wr && hit_txth) s_d.tx_thr = clamp_thr(reg_wdata);
        if (wr && hit_rxth) s_d.rx_thr = clamp_thr(reg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // flush sequencers, one per direction
    flush_ctl #(.CYCLES(FLUSH_CYCLES)) u_tx_flush (
        .clk(clk), .rst_n(rst_n),
        .start(wr && hit_ctrl && reg_wdata[C_TX_FLUSH]),
        .busy(tx_busy), .done(tx_done)
    );
    flush_ctl #(.CYCLES(FLUSH_CYCLES)) u_rx_flush (
        .clk(clk), .rst_n(rst_n),
        .start(wr && hit_ctrl && reg_wdata[C_RX_FLUSH]),
        .busy(rx_busy), .done(rx_done)
    );

    assign tx_push = wr && hit_txd && !tx_busy;
    assign tx_pop  = seq_tx_pop && !tx_busy;
    assign rx_push = seq_rx_push && !rx_busy;
    assign rx_pop  = rd && hit_rxd && !rx_busy;

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(reg_wdata[7:0]),
        .pop(tx_pop), .clear(tx_done),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );
    byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(seq_rx_data),
        .pop(rx_pop), .clear(rx_done),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign seq_tx_data  = tx_head;
    assign seq_tx_avail = !tx_empty && !tx_busy;

    always_comb begin
        lvl = '0;
        lvl[B_TX_EMPTY] = tx_empty;
        lvl[B_TX_LOW]   = (tx_cnt <= CW'(s_q.tx_thr));
        lvl[B_TX_FULL]  = tx_full;
        lvl[B_RX_EMPTY] = rx_empty;
        lvl[B_RX_HIGH]  = (rx_cnt >= CW'(s_q.rx_thr));
        lvl[B_RX_FULL]  = rx_full;
        ev = '0;
        ev[B_TX_OVR]  = tx_push && tx_full;
        ev[B_DONE]    = evt_done;
        ev[B_DONE_NS] = evt_done_nostop;
        ev[B_ARB]     = evt_arb_lost;
        ev[B_BERR]    = evt_bus_err;
        ev[B_SLV0]    = evt_slave[0];
        ev[B_SLV1]    = evt_slave[1];
        ev[B_SLV2]    = evt_slave[2];
        ev[B_SLV3]    = evt_slave[3];
    end

    irq_status u_irq (
        .clk(clk), .rst_n(rst_n),
        .level(lvl), .set_ev(ev),
        .clr_we(wr && hit_clr), .mask_we(wr && hit_mask), .wdata(reg_wdata),
        .raw(raw), .mask(mask), .masked(masked), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (rd) begin
            if (hit_ctrl) begin
                reg_rdata[C_TX_FLUSH] = tx_busy;
                reg_rdata[C_RX_FLUSH] = rx_busy;
            end
            if (hit_rxd && !rx_busy && !rx_empty) reg_rdata[7:0] = rx_head;
            if (hit_txth) reg_rdata[THW-1:0] = s_q.tx_thr;
            if (hit_rxth) reg_rdata[THW-1:0] = s_q.rx_thr;
            if (hit_mask) reg_rdata = mask;
            if (hit_raw)  reg_rdata = raw;
            if (hit_mskd) reg_rdata = masked;
        end
    end

    AST_TX_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full) |=> raw[B_TX_OVR]); // R6
    AST_RX_FLUSH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy && !rx_done) |=> $stable(rx_cnt)); // R2
    AST_THR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tx_thr <= THW'(THR_MAX)) && (s_q.rx_thr <= THW'(THR_MAX))); // R10

endmodule

// File: tb/test_xfer_fifo_irq.sv
`timescale 1ns/1ps
module test_xfer_fifo_irq;

    localparam int DEPTH = 32;
    localparam int FLUSH = 8;
    localparam logic [7:0] A_CTRL = 8'h00, A_TXD = 8'h04, A_RXD = 8'h08,
        A_TXTH = 8'h0C, A_RXTH = 8'h10, A_MASK = 8'h14, A_RAW = 8'h18,
        A_MSKD = 8'h1C, A_CLR = 8'h20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_valid = 0, reg_write = 0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic seq_tx_pop = 0;
    logic [7:0] seq_tx_data;
    logic seq_tx_avail;
    logic seq_rx_push = 0;
    logic [7:0] seq_rx_data = '0;
    logic evt_done = 0, evt_done_nostop = 0, evt_arb_lost = 0, evt_bus_err = 0;
    logic [3:0] evt_slave = '0;
    logic irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    xfer_fifo_irq #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH), .ADDR_W(8)) i_xfer_fifo_irq (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_tx_pop(seq_tx_pop), .seq_tx_data(seq_tx_data), .seq_tx_avail(seq_tx_avail),
        .seq_rx_push(seq_rx_push), .seq_rx_data(seq_rx_data),
        .evt_done(evt_done), .evt_done_nostop(evt_done_nostop),
        .evt_arb_lost(evt_arb_lost), .evt_bus_err(evt_bus_err),
        .evt_slave(evt_slave), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_valid = 0;
    endtask

    task automatic sq_push(input logic [7:0] b);
        @(negedge clk);
        seq_rx_push = 1; seq_rx_data = b;
        @(negedge clk);
        seq_rx_push = 0;
    endtask

    task automatic sq_pop(output logic [7:0] b);
        @(negedge clk);
        b = seq_tx_data; seq_tx_pop = 1;
        @(negedge clk);
        seq_tx_pop = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_RAW, v);  chk("R11 raw after reset", v, 32'h33);
        rd(A_MASK, v); chk("R11 mask after reset", v, 0);
        rd(A_CTRL, v); chk("R11 ctrl after reset", v, 0);
        chk("R11 irq after reset", {31'b0, irq}, 0);
        chk("R11 tx avail after reset", {31'b0, seq_tx_avail}, 0);
    endtask

    task automatic t_tx_order();
        logic [7:0] b;
        int errs = 0;
        wr(A_TXD, 32'hA1); wr(A_TXD, 32'hA2); wr(A_TXD, 32'hA3);
        chk("R3 tx avail", {31'b0, seq_tx_avail}, 1);
        for (int i = 0; i < 3; i++) begin
            sq_pop(b);
            if (b !== 8'(8'hA1 + i)) errs++;
        end
        chk("R3 tx order mismatches", errs, 0);
        chk("R3 tx avail after drain", {31'b0, seq_tx_avail}, 0);
    endtask

    task automatic t_rx_order();
        logic [31:0] v;
        int errs = 0;
        sq_push(8'h31); sq_push(8'h32); sq_push(8'h33);
        for (int i = 0; i < 3; i++) begin
            rd(A_RXD, v);
            if (v !== 32'(8'h31 + i)) errs++;
        end
        chk("R3 rx order mismatches", errs, 0);
        rd(A_RXD, v); chk("R4 empty read value", v, 0);
        rd(A_RAW, v); chk("R4 rx still empty", v & 32'h10, 32'h10);
        sq_push(8'h44);
        rd(A_RXD, v); chk("R4 state unchanged by empty read", v, 32'h44);
    endtask

    task automatic t_thresholds();
        logic [31:0] v;
        logic [7:0] b;
        wr(A_TXTH, 20); rd(A_TXTH, v); chk("R10 tx thr clamp", v, 15);
        wr(A_RXTH, 99); rd(A_RXTH, v); chk("R10 rx thr clamp", v, 15);
        wr(A_TXTH, 2); wr(A_RXTH, 3);
        wr(A_TXD, 1); wr(A_TXD, 2); wr(A_TXD, 3);
        rd(A_RAW, v); chk("R5 tx above thr", v & 32'h3, 0);
        sq_pop(b);
        rd(A_RAW, v); chk("R5 tx at thr", v & 32'h3, 32'h2);
        sq_pop(b); sq_pop(b);
        sq_push(1); sq_push(2);
        rd(A_RAW, v); chk("R5 rx below thr", v & 32'h30, 0);
        sq_push(3);
        rd(A_RAW, v); chk("R5 rx at thr", v & 32'h30, 32'h20);
        rd(A_RXD, v); rd(A_RXD, v); rd(A_RXD, v);
    endtask

    task automatic t_full_overrun();
        logic [31:0] v;
        logic [7:0] b;
        int errs = 0;
        for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(i));
        rd(A_RAW, v); chk("R5 tx full no ovr", v & 32'hC, 32'h4);
        wr(A_TXD, 32'hEE);
        rd(A_RAW, v); chk("R6 overrun set", v & 32'h8, 32'h8);
        for (int i = 0; i < DEPTH; i++) begin
            sq_pop(b);
            if (b !== 8'(i)) errs++;
        end
        chk("R6 overrun byte dropped", errs, 0);
        rd(A_RAW, v); chk("R6 overrun sticky", v & 32'hD, 32'h9);
        for (int i = 0; i < DEPTH; i++) sq_push(8'(i + 100));
        rd(A_RAW, v); chk("R5 rx full", v & 32'h40, 32'h40);
        errs = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(A_RXD, v);
            if (v !== 32'(i + 100)) errs++;
        end
        chk("R3 rx full drain order", errs, 0);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        wr(A_TXD, 7); wr(A_TXD, 8); wr(A_TXD, 9);
        wr(A_CTRL, 32'h80);
        rd(A_CTRL, v); chk("R1 tx flush bit held", v, 32'h80);
        wr(A_TXD, 32'h55);
        chk("R2 tx avail during flush", {31'b0, seq_tx_avail}, 0);
        repeat (FLUSH + 4) @(negedge clk);
        rd(A_CTRL, v); chk("R1 tx flush bit self-clears", v, 0);
        rd(A_RAW, v);  chk("R1 R2 tx empty after flush", v & 32'h1, 1);
        chk("R2 tx write ignored in flush", {31'b0, seq_tx_avail}, 0);
        sq_push(8'h61); sq_push(8'h62);
        wr(A_CTRL, 32'h100);
        rd(A_RXD, v);  chk("R2 rx read during flush", v, 0);
        rd(A_CTRL, v); chk("R1 rx flush bit held", v, 32'h100);
        sq_push(8'h77);
        repeat (FLUSH + 4) @(negedge clk);
        rd(A_CTRL, v); chk("R1 rx flush bit self-clears", v, 0);
        rd(A_RAW, v);  chk("R2 rx empty after flush", v & 32'h10, 32'h10);
        rd(A_RXD, v);  chk("R2 rx push ignored in flush", v, 0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        @(negedge clk);
        evt_done = 1; evt_done_nostop = 1; evt_arb_lost = 1; evt_bus_err = 1; evt_slave = 4'hF;
        @(negedge clk);
        evt_done = 0; evt_done_nostop = 0; evt_arb_lost = 0; evt_bus_err = 0; evt_slave = 4'h0;
        rd(A_RAW, v); chk("R7 all events latched", v, 32'h131F_001B);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_RAW, v); chk("R8 clear leaves level bits", v, 32'h13);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_addr = A_CLR; reg_wdata = 32'h0008_0000;
        evt_done = 1;
        @(negedge clk);
        reg_valid = 0; reg_write = 0; evt_done = 0;
        rd(A_RAW, v); chk("R8 set wins over clear", v & 32'h0008_0000, 32'h0008_0000);
        wr(A_CLR, 32'h0008_0000);
        rd(A_RAW, v); chk("R8 single bit cleared", v, 32'h13);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v); chk("R9 mask top bits zero", v, 32'h1FFF_FFFF);
        rd(A_MSKD, v); chk("R9 masked equals raw and mask", v, 32'h13);
        chk("R9 irq on level bits", {31'b0, irq}, 1);
        wr(A_MASK, 32'h0008_0000);
        rd(A_MSKD, v); chk("R9 masked filtered", v, 0);
        chk("R9 irq low when masked out", {31'b0, irq}, 0);
        @(negedge clk); evt_done = 1; @(negedge clk); evt_done = 0;
        #1 chk("R9 irq on done", {31'b0, irq}, 1);
        rd(A_MSKD, v); chk("R9 masked done bit", v, 32'h0008_0000);
        wr(A_CLR, 32'h0008_0000);
        #1 chk("R9 irq after clear", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tx_order();
        t_rx_order();
        t_thresholds();
        t_full_overrun();
        t_flush();
        t_events();
        t_mask();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule